// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one DMA channel. It holds a control word and initial source and destination addresses, and it moves data over a small bus-master interface. A transfer begins on a trigger. The trigger is either a software bit written through the register port or one of four hardware request lines, picked by a select field. Once started, the channel requests the bus, waits for the grant and issues beats. Each beat carries a source address, a destination address and a size, and the bus acknowledges it. A group of beats forms an atomic unit, which is either one beat or a burst of four.

After every atomic unit the channel drops its bus request for at least one cycle. It then asks again, so other masters get a turn. The current count falls by one per unit. In single service mode the channel then waits for a new trigger. In whole service mode it keeps going until the count runs out. At terminal count the channel pulses `done`. It then either reloads its count and addresses from the initial values, or clears its channel-on bit and stays stopped.

Register map (word offsets on `reg_addr`):
- 0: control word.
- 1: initial source address.
- 2: initial destination address.
- 3: trigger register. Bit 0 is channel on, bit 1 is the software trigger (it reads back as pending), bit 2 is the reserved-size error.
- 4: current count.
- 5: current source address.
- 6: current destination address.

Control word fields:
- [19:0]: initial count.
- [21:20]: size.
- [22]: burst of four.
- [23]: whole service.
- [24]: hardware trigger mode.
- [26:25]: hardware line select.
- [27]: stop at terminal count.

Top module: `dma_chan_seq`

## Requirements
- R1: An atomic unit is one beat when ctrl[22]=0 and four beats when ctrl[22]=1. Every beat presents source and destination addresses that both advance by the beat size after each acknowledged beat.
- R2: ctrl[21:20] selects the beat size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. `bus_size` shows this field.
- R3: With ctrl[23]=0 (single service), each trigger runs exactly one atomic unit. The channel then issues no beat until another trigger arrives.
- R4: With ctrl[23]=1 (whole service), one trigger runs atomic units back to back until the current count reaches zero.
- R5: No beat is issued before `bus_gnt`. `bus_req` stays high while waiting for the grant. After the last beat of every unit, `bus_req` is low for at least one cycle before it rises again, so each unit shows its own rising edge.
- R6: With ctrl[24]=1, the trigger is `hw_req[ctrl[26:25]]`. The other hardware lines have no effect.
- R7: With ctrl[24]=0, `hw_req` has no effect. Writing 1 to bit 1 of offset 3 starts the channel, and `bus_req` is high after the second rising edge counted from the edge that captures that write.
- R8: The current count (offset 4) loads from ctrl[19:0] when offset 0 is written. It drops by one after each completed unit.
- R9: With ctrl[27]=0, at terminal count the current count and the current addresses (offsets 5 and 6) reload from their initial values, and the channel-on bit stays 1.
- R10: With ctrl[27]=1, terminal count clears the channel-on bit (offset 3 bit 0). The count stays 0, the addresses stay at their end values, and later hardware requests start nothing.
- R11: `done` is high for exactly one cycle at each terminal count, with either setting of ctrl[27].
- R12: With size code 3, a trigger starts no bus request and sets the error bit (offset 3 bit 2). The next write to offset 0 clears that bit.
- R13: After reset, `bus_req`, `bus_valid` and `done` are low, and offsets 0, 3 and 4 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hw_req | input | 4 | Hardware request lines |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Beat presented |
| bus_src_addr | output | 32 | Source address of the current beat |
| bus_dst_addr | output | 32 | Destination address of the current beat |
| bus_size | output | 2 | Beat size code |
| bus_ack | input | 1 | Beat accepted |
| done | output | 1 | Terminal-count pulse |

## Verification
A software trigger is captured on the edge that takes the write. The idle sequencer sees it on the next edge, so `bus_req` is sampled high one cycle after the write cycle. The bench checks this timing exactly.

Each beat completes in the cycle its acknowledge is seen, and the release cycle follows the last beat. The counters, the address updates and the `done` pulse therefore land on that release edge. The bench monitor samples beats, request edges and `done` at every rising edge, so it sees each event in the cycle it happens. End-state register reads are made only after the monitor has seen the terminal `done`, or the falling request of a single-service unit, plus a few settle cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int REG_W    = 32;
    localparam int CNT_W    = 20;
    localparam int HW_LINES = 4;
    localparam int SEL_W    = $clog2(HW_LINES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // Control word, LSB first: count, size, burst, whole, hw_mode, hw_sel, stop
    typedef struct packed {
        logic             stop_at_end;
        logic [SEL_W-1:0] hw_sel;
        logic             hw_mode;
        logic             whole;
        logic             burst;
        size_e            size;
        logic [CNT_W-1:0] count;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_REL
    } state_e;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_SRC   = 3'd1;
    localparam logic [2:0] RA_DST   = 3'd2;
    localparam logic [2:0] RA_TRIG  = 3'd3;
    localparam logic [2:0] RA_CNT   = 3'd4;
    localparam logic [2:0] RA_CSRC  = 3'd5;
    localparam logic [2:0] RA_CDST  = 3'd6;

    function automatic logic [2:0] size_bytes(input size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_trig_sel.sv
module dma_trig_sel #(
    parameter int NUM_HW = 4,
    parameter int SEL_W  = $clog2(NUM_HW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_HW-1:0] hw_req,
    input  logic              hw_mode,
    input  logic [SEL_W-1:0]  hw_sel,
    input  logic              sw_set,
    input  logic              consume,
    output logic              trig,
    output logic              sw_pend
);

    logic sw_pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            sw_pend_q <= 1'b0;
        else if (sw_set)
            sw_pend_q <= 1'b1;
        else if (consume)
            sw_pend_q <= 1'b0;
    end

    assign sw_pend = sw_pend_q;
    assign trig    = hw_mode ? hw_req[hw_sel] : sw_pend_q;

    p_sw_capture_r7: assert property (@(posedge clk) disable iff (rst)
        sw_set |=> sw_pend_q);

endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_src,
    input  logic              load_dst,
    input  logic              load_cnt,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [CNT_W-1:0]  cnt_init,
    input  logic              beat_adv,
    input  logic [2:0]        step_bytes,
    input  logic              unit_done,
    input  logic              reload,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              last_unit,
    output logic              cnt_zero
);

    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wrap;

    assign last_unit = (cnt_q == CNT_W'(1));
    assign cnt_zero  = (cnt_q == '0);
    assign wrap      = unit_done && last_unit && reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_cnt) begin
            cnt_q <= cnt_init;
        end else if (unit_done) begin
            cnt_q <= wrap ? cnt_init : cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
        end else if (load_src || wrap) begin
            src_q <= src_init;
        end else if (beat_adv) begin
            src_q <= src_q + ADDR_W'(step_bytes);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q <= '0;
        end else if (load_dst || wrap) begin
            dst_q <= dst_init;
        end else if (beat_adv) begin
            dst_q <= dst_q + ADDR_W'(step_bytes);
        end
    end

    assign cur_src = src_q;
    assign cur_dst = dst_q;
    assign cur_cnt = cnt_q;

    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        (unit_done && !last_unit && !load_cnt) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    p_reload_count_r9: assert property (@(posedge clk) disable iff (rst)
        (unit_done && last_unit && reload && !load_cnt) |=> cnt_q == $past(cnt_init));

    p_stop_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (unit_done && last_unit && !reload && !load_cnt) |=> cnt_zero);

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int BEAT_W    = $clog2(BURST_LEN)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  trig,
    input  logic  chan_on,
    input  logic  cnt_zero,
    input  logic  last_unit,
    input  size_e size,
    input  logic  burst,
    input  logic  whole,
    input  logic  bus_gnt,
    input  logic  bus_ack,
    output logic  bus_req,
    output logic  bus_valid,
    output logic  consume,
    output logic  err_set,
    output logic  beat_adv,
    output logic  unit_done,
    output logic  done
);

    state_e            state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic              last_beat;

    assign last_beat = !burst || (beat_q == BEAT_W'(BURST_LEN - 1));

    always_comb begin
        state_d   = state_q;
        beat_d    = beat_q;
        bus_req   = 1'b0;
        bus_valid = 1'b0;
        consume   = 1'b0;
        err_set   = 1'b0;
        beat_adv  = 1'b0;
        unit_done = 1'b0;
        done      = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (trig && chan_on && !cnt_zero) begin
                    consume = 1'b1;
                    if (size == SZ_RSVD)
                        err_set = 1'b1;
                    else
                        state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    state_d = ST_XFER;
                    beat_d  = '0;
                end
            end
            ST_XFER: begin
                bus_req   = 1'b1;
                bus_valid = 1'b1;
                if (bus_ack) begin
                    beat_adv = 1'b1;
                    if (last_beat)
                        state_d = ST_REL;
                    else
                        beat_d = beat_q + BEAT_W'(1);
                end
            end
            ST_REL: begin
                unit_done = 1'b1;
                done      = last_unit;
                state_d   = (!last_unit && whole) ? ST_REQ : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    p_release_after_unit_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER && bus_ack && last_beat) |=> !bus_req);

    p_wait_grant_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REQ && !bus_gnt) |=> !bus_valid);

    p_whole_rerequest_r4: assert property (@(posedge clk) disable iff (rst)
        (unit_done && !last_unit && whole) |=> bus_req);

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_no_rsvd_start_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(size) != SZ_RSVD);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BURST_LEN = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [HW_LINES-1:0] hw_req,
    output logic                bus_req,
    input  logic                bus_gnt,
    output logic                bus_valid,
    output logic [ADDR_W-1:0]   bus_src_addr,
    output logic [ADDR_W-1:0]   bus_dst_addr,
    output logic [1:0]          bus_size,
    input  logic                bus_ack,
    output logic                done
);

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] src_init_q, dst_init_q;
    logic              chan_on_q, err_q;

    logic wr_ctrl, wr_src, wr_dst, wr_trig;
    logic trig, sw_pend, consume, err_set, beat_adv, unit_done;
    logic last_unit, cnt_zero;
    logic [ADDR_W-1:0] cur_src, cur_dst;
    logic [CNT_W-1:0]  cur_cnt;

    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign wr_src  = reg_we && (reg_addr == RA_SRC);
    assign wr_dst  = reg_we && (reg_addr == RA_DST);
    assign wr_trig = reg_we && (reg_addr == RA_TRIG);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            src_init_q <= '0;
            dst_init_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q     <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (wr_src)  src_init_q <= reg_wdata[ADDR_W-1:0];
            if (wr_dst)  dst_init_q <= reg_wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            chan_on_q <= 1'b0;
        else if (wr_trig)
            chan_on_q <= reg_wdata[0];
        else if (done && ctrl_q.stop_at_end)
            chan_on_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (wr_ctrl)
            err_q <= 1'b0;
        else if (err_set)
            err_q <= 1'b1;
    end

    dma_trig_sel #(
        .NUM_HW (HW_LINES),
        .SEL_W  (SEL_W)
    ) u_trig (
        .clk     (clk),
        .rst     (rst),
        .hw_req  (hw_req),
        .hw_mode (ctrl_q.hw_mode),
        .hw_sel  (ctrl_q.hw_sel),
        .sw_set  (wr_trig && reg_wdata[1]),
        .consume (consume),
        .trig    (trig),
        .sw_pend (sw_pend)
    );

    dma_addr_cnt #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load_src   (wr_src),
        .load_dst   (wr_dst),
        .load_cnt   (wr_ctrl),
        .src_init   (wr_src ? reg_wdata[ADDR_W-1:0] : src_init_q),
        .dst_init   (wr_dst ? reg_wdata[ADDR_W-1:0] : dst_init_q),
        .cnt_init   (wr_ctrl ? reg_wdata[CNT_W-1:0] : ctrl_q.count),
        .beat_adv   (beat_adv),
        .step_bytes (size_bytes(ctrl_q.size)),
        .unit_done  (unit_done),
        .reload     (!ctrl_q.stop_at_end),
        .cur_src    (cur_src),
        .cur_dst    (cur_dst),
        .cur_cnt    (cur_cnt),
        .last_unit  (last_unit),
        .cnt_zero   (cnt_zero)
    );

    dma_fsm #(
        .BURST_LEN (BURST_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .chan_on   (chan_on_q),
        .cnt_zero  (cnt_zero),
        .last_unit (last_unit),
        .size      (ctrl_q.size),
        .burst     (ctrl_q.burst),
        .whole     (ctrl_q.whole),
        .bus_gnt   (bus_gnt),
        .bus_ack   (bus_ack),
        .bus_req   (bus_req),
        .bus_valid (bus_valid),
        .consume   (consume),
        .err_set   (err_set),
        .beat_adv  (beat_adv),
        .unit_done (unit_done),
        .done      (done)
    );

    assign bus_src_addr = cur_src;
    assign bus_dst_addr = cur_dst;
    assign bus_size     = ctrl_q.size;

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = REG_W'(ctrl_q);
            RA_SRC:  reg_rdata = REG_W'(src_init_q);
            RA_DST:  reg_rdata = REG_W'(dst_init_q);
            RA_TRIG: reg_rdata = REG_W'({err_q, sw_pend, chan_on_q});
            RA_CNT:  reg_rdata = REG_W'(cur_cnt);
            RA_CSRC: reg_rdata = REG_W'(cur_src);
            RA_CDST: reg_rdata = REG_W'(cur_dst);
            default: reg_rdata = '0;
        endcase
    end

    p_off_at_end_r10: assert property (@(posedge clk) disable iff (rst)
        (done && ctrl_q.stop_at_end && !wr_trig) |=> !chan_on_q);

    p_on_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !ctrl_q.stop_at_end && !wr_trig && chan_on_q) |=> chan_on_q);

    p_err_blocks_r12: assert property (@(posedge clk) disable iff (rst)
        err_set |=> !bus_req);

endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  hw_req = '0;
    logic        bus_req, bus_gnt, bus_valid, bus_ack, done;
    logic [31:0] bus_src_addr, bus_dst_addr;
    logic [1:0]  bus_size;
    logic        gnt_en = 1'b1;

    always #10 clk = ~clk;

    assign bus_gnt = bus_req && gnt_en;
    assign bus_ack = bus_valid;

    dma_chan_seq dut (
        .clk          (clk),
        .rst          (rst),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .hw_req       (hw_req),
        .bus_req      (bus_req),
        .bus_gnt      (bus_gnt),
        .bus_valid    (bus_valid),
        .bus_src_addr (bus_src_addr),
        .bus_dst_addr (bus_dst_addr),
        .bus_size     (bus_size),
        .bus_ack      (bus_ack),
        .done         (done)
    );

    int checks = 0;
    int errors = 0;

    // Monitor state
    int          beats, units, dones, addr_err, done_err;
    logic [31:0] exp_src, exp_dst;
    int          mon_bytes;
    logic [1:0]  mon_size;
    logic        prev_req = 1'b0;
    logic        prev_done = 1'b0;

    always @(posedge clk) begin
        if (!rst) begin
            if (bus_valid && bus_ack) begin
                beats++;
                if (bus_src_addr !== exp_src || bus_dst_addr !== exp_dst || bus_size !== mon_size)
                    addr_err++;
                exp_src = exp_src + 32'(mon_bytes);
                exp_dst = exp_dst + 32'(mon_bytes);
            end
            if (bus_req && !prev_req) units++;
            if (done) dones++;
            if (done && prev_done) done_err++;
        end
        prev_req  = bus_req;
        prev_done = done;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic mon_clear(input logic [31:0] s, input logic [31:0] dd, input logic [1:0] sz);
        beats = 0; units = 0; dones = 0; addr_err = 0; done_err = 0;
        exp_src = s; exp_dst = dd; mon_size = sz; mon_bytes = 1 << sz;
    endtask

    function automatic logic [31:0] cword(input logic stop, input logic [1:0] sel,
                                          input logic hwm, input logic whl, input logic brst,
                                          input logic [1:0] sz, input logic [19:0] cnt);
        return {4'b0, stop, sel, hwm, whl, brst, sz, cnt};
    endfunction

    // Vector: [12] stop, [11] whole, [10] burst, [9:8] size, [7:0] count
    localparam int NVEC = 6;
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 2'd0, 8'd3},
        {1'b1, 1'b1, 1'b1, 2'd1, 8'd2},
        {1'b0, 1'b1, 1'b0, 2'd2, 8'd4},
        {1'b1, 1'b0, 1'b1, 2'd2, 8'd2},
        {1'b1, 1'b1, 1'b1, 2'd0, 8'd1},
        {1'b0, 1'b0, 1'b0, 2'd1, 8'd5}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog actual=expired expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        mon_clear(0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        check("R13 bus_req", 32'(bus_req), 0);
        check("R13 bus_valid", 32'(bus_valid), 0);
        check("R13 done", 32'(done), 0);
        rd(3'd0, rv); check("R13 ctrl", rv, 0);
        rd(3'd3, rv); check("R13 trig", rv, 0);
        rd(3'd4, rv); check("R13 count", rv, 0);

        // Vector table: R1 R2 R3 R4 R5 R8 R9 R10 R11
        for (int i = 0; i < NVEC; i++) begin
            logic        stop, whl, brst;
            logic [1:0]  sz;
            int          cnt, bpu, bytes;
            logic [31:0] s0, d0;
            stop = VEC[i][12]; whl = VEC[i][11]; brst = VEC[i][10];
            sz = VEC[i][9:8]; cnt = int'(VEC[i][7:0]);
            bpu = brst ? 4 : 1; bytes = 1 << sz;
            s0 = 32'h1000 + 32'(i) * 32'h100;
            d0 = 32'h8000 + 32'(i) * 32'h100;
            wr(3'd1, s0);
            wr(3'd2, d0);
            wr(3'd0, cword(stop, 2'd0, 1'b0, whl, brst, sz, 20'(cnt)));
            wr(3'd3, 32'h1);
            mon_clear(s0, d0, sz);
            if (whl) begin
                wr(3'd3, 32'h3);
                for (int k = 0; k < 3000 && dones == 0; k++) @(negedge clk);
            end else begin
                for (int u = 0; u < cnt; u++) begin
                    wr(3'd3, 32'h3);
                    for (int k = 0; k < 500 && !(units == u + 1 && !bus_req); k++) @(negedge clk);
                    repeat (3) @(negedge clk);
                    if (u == 0) begin
                        repeat (10) @(negedge clk);
                        check("R3 one unit per trigger", 32'(beats), 32'(bpu));
                        rd(3'd4, rv); check("R8 count after one unit", rv, 32'(cnt - 1));
                    end
                end
            end
            repeat (3) @(negedge clk);
            check("R1 beat total", 32'(beats), 32'(cnt * bpu));
            check("R2 beat addresses", 32'(addr_err), 0);
            check("R5 one request edge per unit", 32'(units), 32'(cnt));
            check("R11 done once", 32'(dones), 1);
            check("R11 done width", 32'(done_err), 0);
            rd(3'd3, rv);
            check(stop ? "R10 channel off" : "R9 channel stays on", 32'(rv[0]), 32'(!stop));
            rd(3'd4, rv);
            check(stop ? "R10 count zero" : "R9 count reloaded", rv, stop ? 0 : 32'(cnt));
            rd(3'd5, rv);
            check(stop ? "R10 source at end" : "R9 source reloaded", rv,
                  stop ? s0 + 32'(cnt * bpu * bytes) : s0);
            rd(3'd6, rv);
            check(stop ? "R10 dest at end" : "R9 dest reloaded", rv,
                  stop ? d0 + 32'(cnt * bpu * bytes) : d0);
        end

        // R6 hardware line selection, then R10 channel off ignores requests
        wr(3'd1, 32'h2000);
        wr(3'd2, 32'h3000);
        wr(3'd0, cword(1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 20'd1));
        wr(3'd3, 32'h1);
        mon_clear(32'h2000, 32'h3000, 2'd0);
        hw_req = 4'b1011;
        repeat (10) @(negedge clk);
        check("R6 unselected lines ignored", 32'(beats), 0);
        hw_req = 4'b0100;
        repeat (10) @(negedge clk);
        check("R6 selected line starts", 32'(beats), 1);
        check("R11 done in hw mode", 32'(dones), 1);
        repeat (10) @(negedge clk);
        hw_req = 4'b0000;
        check("R10 no restart after stop", 32'(beats), 1);

        // R7 software mode ignores hardware lines; start timing
        wr(3'd0, cword(1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 20'd1));
        wr(3'd3, 32'h1);
        mon_clear(32'h2000, 32'h3000, 2'd0);
        hw_req = 4'b1111;
        repeat (10) @(negedge clk);
        check("R7 hw lines ignored", 32'(beats), 0);
        hw_req = 4'b0000;
        wr(3'd3, 32'h3);
        check("R7 not yet requesting", 32'(bus_req), 0);
        @(negedge clk);
        check("R7 request timing", 32'(bus_req), 1);
        repeat (10) @(negedge clk);
        check("R7 software start beats", 32'(beats), 1);

        // R5 no beat before grant
        gnt_en = 1'b0;
        wr(3'd1, 32'h4000);
        wr(3'd2, 32'h5000);
        wr(3'd0, cword(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2, 20'd1));
        mon_clear(32'h4000, 32'h5000, 2'd2);
        wr(3'd3, 32'h3);
        repeat (5) @(negedge clk);
        check("R5 request held", 32'(bus_req), 1);
        check("R5 no beat without grant", 32'(bus_valid), 0);
        gnt_en = 1'b1;
        repeat (15) @(negedge clk);
        check("R1 burst after grant", 32'(beats), 4);
        check("R2 word addresses", 32'(addr_err), 0);

        // R12 reserved size
        wr(3'd0, cword(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 20'd2));
        mon_clear(32'h4000, 32'h5000, 2'd3);
        wr(3'd3, 32'h3);
        repeat (10) @(negedge clk);
        check("R12 no request", 32'(units), 0);
        check("R12 no beats", 32'(beats), 0);
        rd(3'd3, rv); check("R12 error set", 32'(rv[2]), 1);
        wr(3'd0, cword(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 20'd2));
        rd(3'd3, rv); check("R12 error cleared", 32'(rv[2]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule